// File: doc/BRIEF.md
# ADC Conversion Request Sequencer

This block runs one conversion on an external general-purpose ADC. The ADC is reached only through a simple 8-bit register port. A requester pulses `req` with a channel number, an averaging sample count, a trigger-edge flag, a trigger-delay byte and a mode select. The mode is either software-started or hardware-triggered. The sequencer then performs these steps in order:

1. Poll the converter's busy flag.
2. Enable the converter.
3. Program the setup byte and the control bits.
4. Either start the conversion or program the trigger delay.
5. Wait for the conversion-end pulse.
6. Read back the two result bytes.
7. Switch the converter off.

It finishes with a one-cycle `done` pulse that carries a 16-bit raw result and an error code. Any failed attempt switches the converter off, and the whole sequence is then run once more before a failure is reported.

The register port is a single-cycle request/acknowledge interface. The sequencer raises `bus_req` and holds the address, direction and write data until `bus_ack` is seen on a clock edge. `bus_rdata` and `bus_err` are valid in that same cycle. The poll spacing and both completion timeouts are cycle counts derived from the `CLK_HZ` parameter.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are 0 and `err_code` is 0.
- R2: Each attempt reads status offset 0x04 and treats bit 0 as busy. It makes up to 10 reads, with at least `CLK_HZ/1000*POLL_MS` idle cycles between reads. If the 10th read still shows busy, the attempt fails with code 1.
- R3: Once the converter is not busy, offset 0x00 is read and written back with bit 0 (0x01) set.
- R4: The setup byte is the channel OR'd with an averaging code: 0x00 for a count of 1, 0x20 for 4, 0x40 for 8, and 0x60 for any other count. It is written to offset 0x01 in software mode (`req_hw`=0) and to offset 0x02 in hardware mode.
- R5: Offset 0x00 is then rewritten with these bits added to its enabled value:
  - 0x40, always;
  - 0x02, in hardware mode;
  - 0x10, in hardware mode with `req_edge`=1;
  - 0x80, when the channel equals `CUR_CH_A` (10) or `CUR_CH_B` (11).
- R6: Hardware mode writes the delay byte to offset 0x03. Software mode instead rewrites offset 0x00 with bit 0x04 added.
- R7: The sequencer waits for a `conv_end` pulse. If none arrives within `CLK_HZ/2` cycles (software mode) or `2*CLK_HZ` cycles (hardware mode), the attempt fails with code 2.
- R8: The result is read low byte then high byte, from 0x05/0x06 in software mode or 0x07/0x08 in hardware mode. `result` = {high, low}. `done` pulses for one cycle with `err_code` 0.
- R9: Offset 0x00 is written with 0x00 after a good read and after every failure. This write comes before `done`.
- R10: A failed attempt is retried once, starting again from the busy poll. If the second attempt also fails, `done` pulses with its code and `result` is 0. A bus access answered with `bus_err` fails the attempt with code 3.
- R11: A `req` pulse that arrives while `busy` is high is ignored.
- R12: While `bus_req` is high and `bus_ack` is low, the address, direction and write data hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start pulse, accepted when idle |
| req_chan | input | CH_W | Channel number |
| req_avg | input | 8 | Number of samples to average |
| req_edge | input | 1 | Falling-edge trigger select (hardware mode) |
| req_dly | input | 8 | Trigger delay value (hardware mode) |
| req_hw | input | 1 | 1 = hardware-triggered, 0 = software-started |
| busy | output | 1 | A conversion request is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Raw conversion result |
| err_code | output | 2 | 0 ok, 1 busy timeout, 2 completion timeout, 3 bus error |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 4 | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access acknowledge |
| bus_rdata | input | 8 | Read data, valid with acknowledge |
| bus_err | input | 1 | Access failed, valid with acknowledge |
| conv_end | input | 1 | Conversion-end pulse from the ADC |

## Verification
A wrong state or bit in this sequencer shows up as a register write to the wrong offset or with the wrong value. The model of the register file sees it on the very access where it happens, well before `done`. A wrong count shows up differently:
- a poll count or retry count that is off changes how many status reads, start writes or disable writes are made before `done`;
- a wrong timeout length moves the `done` pulse by hundreds of cycles.

A result pair taken from the wrong mode returns a filler value that cannot be mistaken for the programmed data.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int POLL_MS   = 10,
  parameter int MAX_POLLS = 10,
  parameter int CH_W      = 5,
  parameter int CUR_CH_A  = 10,
  parameter int CUR_CH_B  = 11
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [CH_W-1:0] req_chan,
  input  logic [7:0]      req_avg,
  input  logic            req_edge,
  input  logic [7:0]      req_dly,
  input  logic            req_hw,
  output logic            busy,
  output logic            done,
  output logic [15:0]     result,
  output logic [1:0]      err_code,
  output logic            bus_req,
  output logic            bus_we,
  output logic [3:0]      bus_addr,
  output logic [7:0]      bus_wdata,
  input  logic            bus_ack,
  input  logic [7:0]      bus_rdata,
  input  logic            bus_err,
  input  logic            conv_end
);
  localparam int TW       = 32;
  localparam int POLL_CYC = (CLK_HZ / 1000) * POLL_MS;
  localparam int SW_TMO   = CLK_HZ / 2;
  localparam int HW_TMO   = CLK_HZ * 2;
  localparam logic [1:0] E_OK = 2'd0, E_BUSY = 2'd1, E_TMO = 2'd2, E_BUS = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_PWAIT, S_EN_RD, S_EN_WR, S_SETUP, S_CFG,
    S_DLY, S_START, S_WAIT, S_RD_LO, S_RD_HI, S_DIS
  } st_t;

  st_t             state;
  logic [CH_W-1:0] q_chan;
  logic [7:0]      q_avg, q_dly, ctl, lo;
  logic            q_edge, q_hw, retried;
  logic [7:0]      polls;
  logic [TW-1:0]   tmr;
  logic [1:0]      fail;

  wire acc      = bus_req & bus_ack;
  wire cur_ch   = (q_chan == CH_W'(CUR_CH_A)) || (q_chan == CH_W'(CUR_CH_B));
  wire [TW-1:0] tmo_lim = q_hw ? TW'(HW_TMO) : TW'(SW_TMO);
  wire [1:0] fin_code = (fail != E_OK) ? fail : (bus_err ? E_BUS : E_OK);

  logic [7:0] avg_code, setup_byte, cfg_byte;
  always_comb begin
    case (q_avg)
      8'd1:    avg_code = 8'h00;
      8'd4:    avg_code = 8'h20;
      8'd8:    avg_code = 8'h40;
      default: avg_code = 8'h60;
    endcase
    setup_byte = 8'(q_chan) | avg_code;
    cfg_byte = ctl | 8'h40 | (q_hw ? 8'h02 : 8'h00) |
               ((q_hw && q_edge) ? 8'h10 : 8'h00) | (cur_ch ? 8'h80 : 8'h00);
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 4'h0; bus_wdata = 8'h00;
    case (state)
      S_POLL:  bus_addr = 4'h4;
      S_EN_RD: bus_addr = 4'h0;
      S_EN_WR: begin bus_we = 1'b1; bus_wdata = ctl | 8'h01; end
      S_SETUP: begin bus_we = 1'b1; bus_addr = q_hw ? 4'h2 : 4'h1; bus_wdata = setup_byte; end
      S_CFG:   begin bus_we = 1'b1; bus_wdata = cfg_byte; end
      S_DLY:   begin bus_we = 1'b1; bus_addr = 4'h3; bus_wdata = q_dly; end
      S_START: begin bus_we = 1'b1; bus_wdata = ctl | 8'h04; end
      S_RD_LO: bus_addr = q_hw ? 4'h7 : 4'h5;
      S_RD_HI: bus_addr = q_hw ? 4'h8 : 4'h6;
      S_DIS:   bus_we = 1'b1;
      default: bus_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; q_chan <= '0; q_avg <= '0; q_dly <= '0; q_edge <= 1'b0;
      q_hw <= 1'b0; ctl <= '0; lo <= '0; retried <= 1'b0; polls <= '0;
      tmr <= '0; fail <= E_OK; done <= 1'b0; result <= '0; err_code <= E_OK;
    end else begin
      done <= 1'b0;
      if (acc && bus_err && state != S_DIS) begin
        fail  <= E_BUS;
        state <= S_DIS;
      end else begin
        case (state)
          S_IDLE: if (req) begin
            q_chan <= req_chan; q_avg <= req_avg; q_edge <= req_edge;
            q_dly <= req_dly; q_hw <= req_hw;
            retried <= 1'b0; fail <= E_OK; polls <= '0; state <= S_POLL;
          end
          S_POLL: if (acc) begin
            if (!bus_rdata[0]) state <= S_EN_RD;
            else if (polls == 8'(MAX_POLLS - 1)) begin fail <= E_BUSY; state <= S_DIS; end
            else begin polls <= polls + 8'd1; tmr <= '0; state <= S_PWAIT; end
          end
          S_PWAIT:
            if (tmr >= TW'(POLL_CYC - 1)) state <= S_POLL;
            else tmr <= tmr + 1'b1;
          S_EN_RD: if (acc) begin ctl <= bus_rdata; state <= S_EN_WR; end
          S_EN_WR: if (acc) begin ctl <= ctl | 8'h01; state <= S_SETUP; end
          S_SETUP: if (acc) state <= S_CFG;
          S_CFG:   if (acc) begin ctl <= cfg_byte; state <= q_hw ? S_DLY : S_START; end
          S_DLY, S_START: if (acc) begin tmr <= '0; state <= S_WAIT; end
          S_WAIT:
            if (conv_end) state <= S_RD_LO;
            else if (tmr >= tmo_lim - 1'b1) begin fail <= E_TMO; state <= S_DIS; end
            else tmr <= tmr + 1'b1;
          S_RD_LO: if (acc) begin lo <= bus_rdata; state <= S_RD_HI; end
          S_RD_HI: if (acc) begin result <= {bus_rdata, lo}; state <= S_DIS; end
          S_DIS: if (acc) begin
            if (fin_code == E_OK) begin
              done <= 1'b1; err_code <= E_OK; state <= S_IDLE;
            end else if (!retried) begin
              retried <= 1'b1; fail <= E_OK; polls <= '0; state <= S_POLL;
            end else begin
              done <= 1'b1; err_code <= fin_code; result <= '0; state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_off_before_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_req && bus_ack && bus_we && bus_addr == 4'h0 && bus_wdata == 8'h00));

  assert_start_on_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));

  assert_no_stray_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_req) |-> (state == S_PWAIT || state == S_WAIT));
endmodule

// File: tb/adc_conv_seq_test.sv
`timescale 1ns/1ps
module adc_conv_seq_test;
  localparam int CLK_HZ = 1000;
  localparam int POLL_CYC = 10;
  localparam int SW_TMO = 500;
  localparam int HW_TMO = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [4:0] req_chan = '0;
  logic [7:0] req_avg = '0, req_dly = '0;
  logic req_edge = 1'b0, req_hw = 1'b0;
  logic busy, done, bus_req, bus_we;
  logic [15:0] result;
  logic [1:0] err_code;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic bus_ack = 1'b0, bus_err = 1'b0, conv_end = 1'b0;
  logic [7:0] bus_rdata = '0;

  always #5 clk = ~clk;

  adc_conv_seq #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_chan(req_chan), .req_avg(req_avg),
    .req_edge(req_edge), .req_dly(req_dly), .req_hw(req_hw), .busy(busy), .done(done),
    .result(result), .err_code(err_code), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .conv_end(conv_end));

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] regs [16];
  int busy_left = 0, err_addr = -1, conv_lat = 4, conv_cnt = 0;
  bit err_once = 0, conv_on = 1;
  int status_rd = 0, setup_cnt = 0, dly_cnt = 0, start_cnt = 0, dis_cnt = 0;
  int last_poll = -1, min_gap = 1000000;
  logic [3:0] setup_addr; logic [7:0] setup_val, dly_val, ctl_seen;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    conv_end = 1'b0;
    if (conv_cnt > 0) begin conv_cnt--; if (conv_cnt == 0) conv_end = 1'b1; end
    if (bus_req && !bus_ack) begin
      bus_ack = 1'b1;
      bus_err = (int'(bus_addr) == err_addr);
      if (bus_err && err_once) err_addr = -1;
      if (bus_we) begin
        regs[bus_addr] = bus_wdata;
        if (bus_addr == 4'h1 || bus_addr == 4'h2) begin setup_cnt++; setup_addr = bus_addr; setup_val = bus_wdata; end
        if (bus_addr == 4'h3) begin dly_cnt++; dly_val = bus_wdata; ctl_seen = regs[0]; if (conv_on) conv_cnt = conv_lat; end
        if (bus_addr == 4'h0 && bus_wdata == 8'h00) dis_cnt++;
        if (bus_addr == 4'h0 && bus_wdata[2]) begin start_cnt++; ctl_seen = bus_wdata; if (conv_on) conv_cnt = conv_lat; end
      end else if (bus_addr == 4'h4) begin
        status_rd++;
        if (last_poll >= 0 && cyc - last_poll < min_gap) min_gap = cyc - last_poll;
        last_poll = cyc;
        bus_rdata = (busy_left > 0) ? 8'h01 : 8'h00;
        if (busy_left > 0) busy_left--;
      end else bus_rdata = regs[bus_addr];
    end else begin
      bus_ack = 1'b0; bus_err = 1'b0;
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp); end
  endtask

  task automatic prep(input logic [7:0] ctl0, input logic [7:0] sl, input logic [7:0] sh,
                      input logic [7:0] hl, input logic [7:0] hh);
    for (int i = 0; i < 16; i++) regs[i] = 8'hEE;
    regs[0] = ctl0; regs[5] = sl; regs[6] = sh; regs[7] = hl; regs[8] = hh;
    status_rd = 0; setup_cnt = 0; dly_cnt = 0; start_cnt = 0; dis_cnt = 0;
    last_poll = -1; min_gap = 1000000; busy_left = 0; err_addr = -1; err_once = 0; conv_on = 1;
    setup_addr = '0; setup_val = '0; dly_val = '0; ctl_seen = '0;
  endtask

  task automatic issue(input bit hw, input logic [4:0] ch, input logic [7:0] avg,
                       input bit edg, input logic [7:0] dly);
    @(negedge clk);
    req = 1'b1; req_hw = hw; req_chan = ch; req_avg = avg; req_edge = edg; req_dly = dly;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!done) begin
      @(negedge clk); cycles++;
      if (cycles > 20000) begin
        check(0, "watchdog", cycles, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  endtask

  typedef struct packed {
    logic hw; logic [4:0] ch; logic [7:0] avg; logic edg; logic [7:0] dly;
    logic [7:0] lo; logic [7:0] hi; logic [7:0] e_setup; logic [7:0] e_ctl;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{1'b0, 5'd3,  8'd1, 1'b0, 8'h00, 8'h34, 8'h02, 8'h03, 8'h45},
    '{1'b0, 5'd10, 8'd4, 1'b0, 8'h00, 8'hFF, 8'h03, 8'h2A, 8'hC5},
    '{1'b1, 5'd11, 8'd8, 1'b1, 8'h5A, 8'h10, 8'h01, 8'h4B, 8'hD3},
    '{1'b1, 5'd7,  8'd16, 1'b0, 8'h0F, 8'h00, 8'h00, 8'h67, 8'h43},
    '{1'b0, 5'd1,  8'd5, 1'b1, 8'h00, 8'hAB, 8'hCD, 8'h61, 8'h45}
  };

  initial begin
    int n;
    prep(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && bus_req == 0 && err_code == 0, "R1 reset state",
          {busy, done, bus_req, err_code}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && bus_req == 0, "R1 idle after release", {busy, bus_req}, 0);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      if (v.hw) prep(8'h00, 8'hEE, 8'hEE, v.lo, v.hi);
      else      prep(8'h00, v.lo, v.hi, 8'hEE, 8'hEE);
      issue(v.hw, v.ch, v.avg, v.edg, v.dly);
      wait_done(n);
      check(result == {v.hi, v.lo} && err_code == 0, "R8 result", result, {v.hi, v.lo});
      check(setup_addr == (v.hw ? 4'h2 : 4'h1), "R4 setup offset", setup_addr, v.hw ? 2 : 1);
      check(setup_val == v.e_setup, "R4 setup byte", setup_val, v.e_setup);
      check(ctl_seen == v.e_ctl, "R5 control bits", ctl_seen, v.e_ctl);
      if (v.hw) check(dly_cnt == 1 && dly_val == v.dly && start_cnt == 0, "R6 delay write", dly_val, v.dly);
      else      check(start_cnt == 1 && dly_cnt == 0, "R6 start bit", start_cnt, 1);
      check(regs[0] == 8'h00 && dis_cnt == 1, "R9 disable after success", regs[0], 0);
      check(status_rd == 1, "R3 single poll when free", status_rd, 1);
      @(negedge clk);
      check(done == 0, "R8 done one cycle", done, 0);
    end

    prep(8'h00, 8'h21, 8'h00, 8'hEE, 8'hEE);
    busy_left = 3;
    issue(0, 5'd2, 8'd1, 0, 0);
    wait_done(n);
    check(err_code == 0 && result == 16'h0021, "R2 success after busy polls", result, 16'h0021);
    check(status_rd == 4, "R2 poll count", status_rd, 4);
    check(min_gap >= POLL_CYC, "R2 poll spacing", min_gap, POLL_CYC);

    prep(8'h20, 8'h00, 8'h00, 8'h00, 8'h00);
    busy_left = 1000;
    issue(0, 5'd2, 8'd1, 0, 0);
    wait_done(n);
    check(err_code == 2'd1, "R2 busy timeout code", err_code, 1);
    check(status_rd == 20, "R10 two attempts of ten reads", status_rd, 20);
    check(regs[0] == 8'h00 && setup_cnt == 0, "R9 disable on busy fail", regs[0], 0);
    check(result == 0, "R10 result cleared on fail", result, 0);

    prep(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    conv_on = 0;
    issue(0, 5'd4, 8'd1, 0, 0);
    wait_done(n);
    check(err_code == 2'd2, "R7 sw completion timeout", err_code, 2);
    check(n >= 2 * SW_TMO && n < 2 * HW_TMO, "R7 sw timeout length", n, 2 * SW_TMO);
    check(start_cnt == 2 && dis_cnt == 2, "R10 retry once", start_cnt, 2);

    prep(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    conv_on = 0;
    issue(1, 5'd4, 8'd1, 0, 8'h07);
    wait_done(n);
    check(err_code == 2'd2 && n >= 2 * HW_TMO, "R7 hw timeout length", n, 2 * HW_TMO);

    prep(8'h00, 8'hEE, 8'hEE, 8'h9C, 8'h02);
    err_addr = 7; err_once = 1;
    issue(1, 5'd6, 8'd4, 0, 8'h11);
    wait_done(n);
    check(err_code == 0 && result == 16'h029C, "R10 retry recovers", result, 16'h029C);
    check(dly_cnt == 2 && dis_cnt == 2, "R9 R10 disable then rerun", dis_cnt, 2);

    prep(8'h20, 8'h00, 8'h00, 8'h00, 8'h00);
    err_addr = 1;
    issue(0, 5'd6, 8'd4, 0, 0);
    wait_done(n);
    check(err_code == 2'd3, "R10 bus error code", err_code, 3);
    check(regs[0] == 8'h00 && dis_cnt == 2, "R9 disable on bus error", regs[0], 0);

    prep(8'h00, 8'h55, 8'h01, 8'hEE, 8'hEE);
    issue(0, 5'd3, 8'd1, 0, 0);
    repeat (5) @(negedge clk);
    req = 1'b1; req_hw = 1; req_chan = 5'd20; req_avg = 8'd8;
    @(negedge clk);
    req = 1'b0;
    wait_done(n);
    check(setup_cnt == 1 && setup_addr == 4'h1 && setup_val == 8'h03, "R11 request while busy ignored",
          setup_val, 8'h03);
    check(result == 16'h0155, "R11 first request result", result, 16'h0155);
    @(negedge clk); @(negedge clk);
    check(busy == 0 && bus_req == 0, "R11 no second run", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule